// File: doc/BRIEF.md
# Link Test Pattern and Lane Alignment Sequencer

This block drives the octet stream of one transmit lane of a JESD204B link layer, one stage ahead of the 8b/10b encoder. In each clock cycle it emits a registered octet, a flag marking that octet as a control character, and a valid strobe. A 3-bit mode select picks what goes out. The choices are ordinary sample data, fixed D21.5 or K28.5 jitter characters, the 12-octet RPAT jitter pattern, or an alignment sequence that repeats forever. In RPAT mode an optional disparity-modify control asks the encoder to flip its running disparity once per pattern period.

In normal mode the block runs the link start-up. While SYNC is held low it sends K28.5 without a break. Once SYNC is released it waits a programmable 0 to 3 whole multiframes and then sends a four-multiframe alignment sequence, which carries the configuration octets. After that it passes user data. Multiframe timing comes from an external strobe that is high in the cycle before the first octet of each multiframe. Mode changes are held back until such a boundary, so a sequence is never cut off part way through.

Top module: `jesd_tpat_seq`

## Requirements
- R1: While reset is low, out_valid and disp_inv are 0. Reset selects mode 000, no disparity change and zero delay, so the first octet after reset with sync_n low is K28.5 (0xBC, out_k=1).
- R2: In mode 000 (or its aliases), while sync_n is low, every octet is K28.5 (0xBC, out_k=1). Inputs sampled in cycle t set the octet shown in cycle t+1.
- R3: Suppose sync_n rises in a cycle without mf_start, and ila_delay holds d at that moment. K28.5 continues until the (d+1)-th multiframe start after the release. That octet is the K28.0 that opens the alignment sequence.
- R4: The alignment sequence lasts exactly 4 multiframes of MF_LEN octets. Every multiframe opens with K28.0 (0x1C, k) and closes with K28.3 (0x7C, k). In the second multiframe, position 1 is K28.4 (0x9C, k), and positions 2 to CFG_LEN+1 carry cfg_octets byte i = cfg_octets[8i+7:8i], with k=0. Every other octet is its own position within the multiframe, with k=0.
- R5: After the alignment sequence, data_in is passed with k=0, one cycle later.
- R6: In mode 000, sync_n low in any state makes the next octet K28.5 and restarts the handshake.
- R7: Mode 001 sends 0xB5 (D21.5) with k=0 continuously. Mode 010 sends 0xBC (K28.5) with k=1 continuously.
- R8: Mode 011 sends one full multiframe of K28.5. It then sends the alignment sequence of R4 back to back without end, and sync_n has no effect.
- R9: Mode 100 sends BE, D7, 23, 47, 6B, 8F, B3, 14, 5E, FB, 35, 59 with k=0, starting at the first octet of the multiframe where the mode takes effect, and restarts after the twelfth.
- R10: disp_inv is a one-cycle pulse on each octet 0xBE of the RPAT pattern, and only while disp_mod is 1 and the mode is 100. In any other mode, disp_mod has no effect.
- R11: test_mode is sampled only in a cycle with mf_start high. It takes effect from the first octet of the next multiframe.
- R12: Mode values 101, 110 and 111 behave exactly like 000.
- R13: out_valid is 1 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_n | input | 1 | Receiver synchronisation request, active low |
| mf_start | input | 1 | High in the cycle before the first octet of a multiframe |
| test_mode | input | 3 | Pattern select, sampled at boundaries |
| disp_mod | input | 1 | Disparity-modify enable for RPAT |
| ila_delay | input | 2 | Extra multiframes before alignment starts |
| cfg_octets | input | CFG_LEN*8 | Configuration octets for the second alignment multiframe |
| data_in | input | 8 | Sample data octet |
| out_octet | output | 8 | Octet to the encoder |
| out_k | output | 1 | Octet is a control character |
| out_valid | output | 1 | Octet is valid |
| disp_inv | output | 1 | Running disparity invert request |

## Verification
The hardest case to reach is the delayed start of the alignment sequence. It needs SYNC released part way through a multiframe, followed by a count of exactly d+1 later boundaries. Every octet before the K28.0 must be checked, and so must every octet of the four alignment multiframes. The bench keeps its own position counter, generates mf_start from it, releases SYNC at position 10, and counts boundaries itself, once with delay 0 and once with delay 3. It also reaches that handoff a second time through an aliased mode value with delay 1, entered in the middle of a multiframe.

// File: rtl/tps_pkg.sv
// Shared types for the link test pattern sequencer.
// Assumes the 3-bit mode codes below. Unused codes fold onto normal data.
package tps_pkg;

    typedef enum logic [2:0] {
        MODE_NORMAL = 3'd0,
        MODE_D215   = 3'd1,
        MODE_K285   = 3'd2,
        MODE_REPILA = 3'd3,
        MODE_RPAT   = 3'd4
    } tmode_e;

    typedef enum logic [2:0] {
        LS_CGS,
        LS_WAIT,
        LS_ILA,
        LS_DATA,
        LS_PRE
    } lstate_e;

    localparam logic [7:0] OCT_K280 = 8'h1C;
    localparam logic [7:0] OCT_K283 = 8'h7C;
    localparam logic [7:0] OCT_K284 = 8'h9C;
    localparam logic [7:0] OCT_K285 = 8'hBC;
    localparam logic [7:0] OCT_D215 = 8'hB5;
    localparam int         RPAT_LEN = 12;

    // Map a raw select onto a defined mode (101..111 -> normal).
    function automatic tmode_e fold_mode(input logic [2:0] raw);
        if (raw > 3'd4) return MODE_NORMAL;
        return tmode_e'(raw);
    endfunction

endpackage

// File: rtl/tps_mf_track.sv
// Multiframe tracker. It follows the octet position inside the multiframe
// and latches the test mode only at boundaries.
// Assumes mf_start is high in the cycle before position 0 is emitted.
// All nxt_* outputs describe the octet that is emitted in the next cycle.
module tps_mf_track
    import tps_pkg::*;
#(
    parameter int MF_LEN = 32,
    localparam int POS_W = $clog2(MF_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mf_start,
    input  logic [2:0]       test_mode,
    output logic [POS_W-1:0] nxt_pos,
    output tmode_e           nxt_mode,
    output logic             mode_chg
);
    logic [POS_W-1:0] pos_q;
    tmode_e           mode_q;
    tmode_e           req_mode;

    // Compute next position and candidate mode.
    always_comb begin
        req_mode = fold_mode(test_mode);
        if (mf_start)                           nxt_pos = '0;
        else if (pos_q == POS_W'(MF_LEN - 1))   nxt_pos = pos_q;
        else                                    nxt_pos = pos_q + 1'b1;
        nxt_mode = mf_start ? req_mode : mode_q;
        mode_chg = mf_start && (req_mode != mode_q);
    end

    // Hold the position and the active mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= POS_W'(MF_LEN - 1);
            mode_q <= MODE_NORMAL;
        end else begin
            pos_q  <= nxt_pos;
            mode_q <= nxt_mode;
        end
    end
endmodule

// File: rtl/tps_link_fsm.sv
// Link start-up sequencer: synchronisation, delayed alignment start,
// the alignment multiframes and user data. It also runs the endlessly
// repeating alignment mode. Any other mode parks it in the sync state.
module tps_link_fsm
    import tps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boundary,
    input  tmode_e     nxt_mode,
    input  logic       mode_chg,
    input  logic       sync_n,
    input  logic [1:0] ila_delay,
    output lstate_e    nxt_state,
    output logic [1:0] nxt_ilamf
);
    lstate_e    state_q;
    logic [1:0] ilamf_q;
    logic [1:0] cnt_q;
    logic [1:0] nxt_cnt;

    // Next-state decision for the octet emitted in the next cycle.
    always_comb begin
        nxt_state = state_q;
        nxt_ilamf = ilamf_q;
        nxt_cnt   = cnt_q;
        if (nxt_mode == MODE_REPILA) begin
            if (mode_chg) begin
                nxt_state = LS_PRE;
                nxt_ilamf = '0;
            end else if (boundary) begin
                if (state_q == LS_ILA) nxt_ilamf = ilamf_q + 1'b1;
                else                   nxt_ilamf = '0;
                nxt_state = LS_ILA;
            end
        end else if (nxt_mode != MODE_NORMAL || mode_chg || !sync_n) begin
            nxt_state = LS_CGS;
            nxt_ilamf = '0;
        end else begin
            unique case (state_q)
                LS_CGS: begin
                    nxt_state = LS_WAIT;
                    nxt_cnt   = ila_delay;
                end
                LS_WAIT: if (boundary) begin
                    if (cnt_q == '0) begin
                        nxt_state = LS_ILA;
                        nxt_ilamf = '0;
                    end else begin
                        nxt_cnt = cnt_q - 1'b1;
                    end
                end
                LS_ILA: if (boundary) begin
                    if (ilamf_q == 2'd3) nxt_state = LS_DATA;
                    else                 nxt_ilamf = ilamf_q + 1'b1;
                end
                LS_DATA: nxt_state = LS_DATA;
                default: nxt_state = LS_CGS;
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LS_CGS;
            ilamf_q <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= nxt_state;
            ilamf_q <= nxt_ilamf;
            cnt_q   <= nxt_cnt;
        end
    end
endmodule

// File: rtl/tps_rpat_gen.sv
// RPAT octet generator. The index restarts at the first octet of the
// multiframe where the pattern mode takes effect and wraps after the
// twelfth octet.
module tps_rpat_gen
    import tps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  tmode_e     nxt_mode,
    input  logic       mode_chg,
    output logic [7:0] nxt_octet,
    output logic       nxt_first
);
    localparam int IDX_W = $clog2(RPAT_LEN);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] nxt_idx;

    // Pattern octet for a given index.
    function automatic logic [7:0] rpat_octet(input logic [IDX_W-1:0] i);
        case (i)
            4'd0:    return 8'hBE;
            4'd1:    return 8'hD7;
            4'd2:    return 8'h23;
            4'd3:    return 8'h47;
            4'd4:    return 8'h6B;
            4'd5:    return 8'h8F;
            4'd6:    return 8'hB3;
            4'd7:    return 8'h14;
            4'd8:    return 8'h5E;
            4'd9:    return 8'hFB;
            4'd10:   return 8'h35;
            default: return 8'h59;
        endcase
    endfunction

    // Advance or restart the index.
    always_comb begin
        if (nxt_mode != MODE_RPAT || mode_chg)        nxt_idx = '0;
        else if (idx_q == IDX_W'(RPAT_LEN - 1))       nxt_idx = '0;
        else                                          nxt_idx = idx_q + 1'b1;
        nxt_octet = rpat_octet(nxt_idx);
        nxt_first = (nxt_mode == MODE_RPAT) && (nxt_idx == '0);
    end

    // Index register.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= nxt_idx;
    end
endmodule

// File: rtl/jesd_tpat_seq.sv
// Top level: test pattern and lane alignment sequencer for one lane.
// Assumes mf_start marks the cycle before each multiframe's first octet,
// MF_LEN >= CFG_LEN + 3, and static mode/delay/config inputs.
// Every output is registered, with one cycle from input to octet.
module jesd_tpat_seq
    import tps_pkg::*;
#(
    parameter int MF_LEN  = 32,
    parameter int CFG_LEN = 14,
    localparam int POS_W  = $clog2(MF_LEN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_n,
    input  logic                 mf_start,
    input  logic [2:0]           test_mode,
    input  logic                 disp_mod,
    input  logic [1:0]           ila_delay,
    input  logic [CFG_LEN*8-1:0] cfg_octets,
    input  logic [7:0]           data_in,
    output logic [7:0]           out_octet,
    output logic                 out_k,
    output logic                 out_valid,
    output logic                 disp_inv
);
    logic [POS_W-1:0] nxt_pos;
    tmode_e           nxt_mode;
    logic             mode_chg;
    lstate_e          nxt_state;
    logic [1:0]       nxt_ilamf;
    logic [7:0]       rp_octet;
    logic             rp_first;
    logic [7:0]       ila_octet;
    logic             ila_k;
    logic [7:0]       sel_octet;
    logic             sel_k;

    tps_mf_track #(.MF_LEN(MF_LEN)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .mf_start  (mf_start),
        .test_mode (test_mode),
        .nxt_pos   (nxt_pos),
        .nxt_mode  (nxt_mode),
        .mode_chg  (mode_chg)
    );

    tps_link_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .boundary  (mf_start),
        .nxt_mode  (nxt_mode),
        .mode_chg  (mode_chg),
        .sync_n    (sync_n),
        .ila_delay (ila_delay),
        .nxt_state (nxt_state),
        .nxt_ilamf (nxt_ilamf)
    );

    tps_rpat_gen u_rpat (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_mode  (nxt_mode),
        .mode_chg  (mode_chg),
        .nxt_octet (rp_octet),
        .nxt_first (rp_first)
    );

    // Alignment sequence octet by multiframe index and position.
    always_comb begin
        ila_octet = 8'(nxt_pos);
        ila_k     = 1'b0;
        if (nxt_pos == '0) begin
            ila_octet = OCT_K280;
            ila_k     = 1'b1;
        end else if (nxt_pos == POS_W'(MF_LEN - 1)) begin
            ila_octet = OCT_K283;
            ila_k     = 1'b1;
        end else if (nxt_ilamf == 2'd1) begin
            if (nxt_pos == POS_W'(1)) begin
                ila_octet = OCT_K284;
                ila_k     = 1'b1;
            end
            for (int i = 0; i < CFG_LEN; i++) begin
                if (int'(nxt_pos) == i + 2) ila_octet = cfg_octets[8*i +: 8];
            end
        end
    end

    // Pick the octet source for the active mode and link state.
    always_comb begin
        sel_octet = OCT_K285;
        sel_k     = 1'b1;
        unique case (nxt_mode)
            MODE_D215: begin
                sel_octet = OCT_D215;
                sel_k     = 1'b0;
            end
            MODE_K285: ;
            MODE_RPAT: begin
                sel_octet = rp_octet;
                sel_k     = 1'b0;
            end
            default: begin
                if (nxt_state == LS_ILA) begin
                    sel_octet = ila_octet;
                    sel_k     = ila_k;
                end else if (nxt_state == LS_DATA) begin
                    sel_octet = data_in;
                    sel_k     = 1'b0;
                end
            end
        endcase
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_octet <= '0;
            out_k     <= 1'b0;
            out_valid <= 1'b0;
            disp_inv  <= 1'b0;
        end else begin
            out_octet <= sel_octet;
            out_k     <= sel_k;
            out_valid <= 1'b1;
            disp_inv  <= disp_mod && rp_first;
        end
    end
endmodule

// File: rtl/tps_checker.sv
// Property checker for jesd_tpat_seq, attached with bind. It watches
// only the ports of the sequencer.
module tps_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       disp_mod,
    input logic [7:0] out_octet,
    input logic       out_k,
    input logic       out_valid,
    input logic       disp_inv
);
    AST_DINV_NEEDS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        disp_inv |-> $past(disp_mod)); // R10

    AST_DINV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_inv |=> !disp_inv); // R10

    AST_DINV_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        disp_inv |-> (!out_k && out_octet == 8'hBE)); // R9

    AST_K_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_k |-> (out_octet == 8'h1C || out_octet == 8'h7C ||
                   out_octet == 8'h9C || out_octet == 8'hBC)); // R4

    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid); // R13
endmodule

bind jesd_tpat_seq tps_checker u_tps_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .disp_mod  (disp_mod),
    .out_octet (out_octet),
    .out_k     (out_k),
    .out_valid (out_valid),
    .disp_inv  (disp_inv)
);

// File: tb/tb_jesd_tpat_seq.sv
`timescale 1ns/1ps
module tb_jesd_tpat_seq;
    localparam int MF  = 32;
    localparam int CFG = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_n = 1'b0;
    logic mf_start = 1'b0;
    logic [2:0] test_mode = 3'd0;
    logic disp_mod = 1'b0;
    logic [1:0] ila_delay = 2'd0;
    logic [CFG*8-1:0] cfg_octets;
    logic [7:0] data_in = 8'h00;
    logic [7:0] out_octet;
    logic out_k, out_valid, disp_inv;

    int n_chk = 0;
    int n_bad = 0;
    int ph = 0;
    int opos = 0;
    bit done = 1'b0;

    localparam logic [7:0] RP [12] = '{8'hBE, 8'hD7, 8'h23, 8'h47, 8'h6B, 8'h8F,
                                       8'hB3, 8'h14, 8'h5E, 8'hFB, 8'h35, 8'h59};

    always #2 clk = ~clk;

    jesd_tpat_seq dut (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .mf_start(mf_start),
        .test_mode(test_mode), .disp_mod(disp_mod), .ila_delay(ila_delay),
        .cfg_octets(cfg_octets), .data_in(data_in), .out_octet(out_octet),
        .out_k(out_k), .out_valid(out_valid), .disp_inv(disp_inv)
    );

    // Compare {valid,k,octet} against expectation.
    task automatic chk_out(string req, logic [8:0] exp);
        n_chk++;
        if ({out_valid, out_k, out_octet} !== {1'b1, exp}) begin
            n_bad++;
            $display("FAIL %s pos=%0d got v=%b k=%b o=%h exp v=1 k=%b o=%h",
                     req, opos, out_valid, out_k, out_octet, exp[8], exp[7:0]);
        end
    endtask

    task automatic chk_bit(string req, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s pos=%0d got %b exp %b", req, opos, got, exp);
        end
    endtask

    // One octet cycle; on return, outputs show position opos.
    task automatic step();
        mf_start = (ph == 0);
        @(posedge clk);
        @(negedge clk);
        opos = ph;
        ph = (ph + 1) % MF;
    endtask

    task automatic step_to(int p);
        do step(); while (opos != p);
    endtask

    function automatic logic [8:0] ila_exp(int mf, int pos);
        if (pos == 0) return {1'b1, 8'h1C};
        if (pos == MF - 1) return {1'b1, 8'h7C};
        if (mf == 1 && pos == 1) return {1'b1, 8'h9C};
        if (mf == 1 && pos >= 2 && pos < CFG + 2) return {1'b0, 8'(8'hA0 + pos - 2)};
        return {1'b0, 8'(pos)};
    endfunction

    // K28.5 until the (d+1)-th boundary, then the full alignment sequence.
    task automatic await_ila(string req, int d);
        int bnd = 0;
        for (int n = 0; n < 8 * MF; n++) begin
            step();
            if (opos == 0) bnd++;
            if (bnd == d + 1) break;
            chk_out(req, {1'b1, 8'hBC});
        end
        chk_out(req, {1'b1, 8'h1C});
        for (int mf = 0; mf < 4; mf++)
            for (int p = (mf == 0) ? 1 : 0; p < MF; p++) begin
                step();
                chk_out("R4", ila_exp(mf, opos));
            end
    endtask

    task automatic t_reset();
        chk_bit("R1 valid", out_valid, 1'b0);
        chk_bit("R1 dinv", disp_inv, 1'b0);
        rst_n = 1'b1;
        step();
        chk_out("R1", {1'b1, 8'hBC});
    endtask

    // Handshake with delay d, then data passthrough.
    task automatic t_cgs_ila(int d);
        sync_n = 1'b0;
        ila_delay = 2'(d);
        step_to(10);
        chk_out("R2", {1'b1, 8'hBC});
        sync_n = 1'b1;
        await_ila("R3", d);
        for (int i = 0; i < 8; i++) begin
            data_in = 8'(8'h31 + i * 37);
            step();
            chk_out("R5", {1'b0, data_in});
        end
    endtask

    task automatic t_resync();
        sync_n = 1'b0;
        step();
        chk_out("R6", {1'b1, 8'hBC});
        step();
        chk_out("R6", {1'b1, 8'hBC});
    endtask

    task automatic t_modes();
        sync_n = 1'b0;
        step_to(5);
        test_mode = 3'd1;
        while (ph != 0) begin step(); chk_out("R11", {1'b1, 8'hBC}); end
        for (int i = 0; i < 40; i++) begin step(); chk_out("R7 d215", {1'b0, 8'hB5}); end
        test_mode = 3'd2;
        while (ph != 0) begin step(); chk_out("R11", {1'b0, 8'hB5}); end
        for (int i = 0; i < 40; i++) begin step(); chk_out("R7 k285", {1'b1, 8'hBC}); end
        test_mode = 3'd5;
        while (ph != 0) step();
        step_to(10);
        chk_out("R12", {1'b1, 8'hBC});
        ila_delay = 2'd1;
        sync_n = 1'b1;
        await_ila("R12", 1);
        data_in = 8'h5A;
        step();
        chk_out("R12", {1'b0, 8'h5A});
    endtask

    task automatic t_rpat();
        disp_mod = 1'b1;
        step_to(7);
        test_mode = 3'd4;
        while (ph != 0) begin step(); chk_bit("R11 dinv", disp_inv, 1'b0); end
        for (int n = 0; n < 36; n++) begin
            step();
            chk_out("R9", {1'b0, RP[n % 12]});
            chk_bit("R10", disp_inv, n % 12 == 0);
        end
        disp_mod = 1'b0;
        for (int n = 0; n < 12; n++) begin step(); chk_bit("R10 off", disp_inv, 1'b0); end
        disp_mod = 1'b1;
        test_mode = 3'd2;
        while (ph != 0) step();
        for (int n = 0; n < 24; n++) begin
            step();
            chk_out("R10 k285", {1'b1, 8'hBC});
            chk_bit("R10 other", disp_inv, 1'b0);
        end
        disp_mod = 1'b0;
    endtask

    task automatic t_repila();
        step_to(3);
        test_mode = 3'd3;
        while (ph != 0) step();
        for (int n = 0; n < MF; n++) begin
            sync_n = n[0];
            step();
            chk_out("R8 pre", {1'b1, 8'hBC});
        end
        for (int r = 0; r < 8; r++)
            for (int p = 0; p < MF; p++) begin
                sync_n = (p % 3 == 0);
                step();
                chk_out("R8", ila_exp(r % 4, opos));
            end
    endtask

    initial begin
        for (int i = 0; i < CFG; i++) cfg_octets[8*i +: 8] = 8'(8'hA0 + i);
        repeat (3) @(negedge clk);
        t_reset();
        t_cgs_ila(0);
        t_resync();
        t_cgs_ila(3);
        t_modes();
        t_rpat();
        t_repila();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule